// File: doc/BRIEF.md
# Data acquisition conversion sequencer

This block runs a multi-sample analog-to-digital acquisition. Software writes a six-bit control word together with a sample interval, a conversion count, a scan-divide ratio and a small scan list of channel/gain entries. A trigger then starts a run, coming either from software or from an external start pin. While acquisition is enabled, the trigger starts a reloadable interval timer. Each time the timer underflows, the block emits a one-cycle conversion strobe, together with the channel and gain that the converter must use for that sample. The run ends on the conversion at which the conversion counter reaches its terminal count. The counter is either a single 16-bit stage or two 16-bit stages cascaded into 32 bits.

Returning 12-bit converter codes are formatted before they are stored. In one mode they are zero-extended as unsigned values. In the other they become sign-extended two's complement: the top code bit is inverted and then sign-extended. The formatted words go into a small show-ahead result FIFO. A DMA request is raised while the FIFO holds data and requests are enabled. A result that arrives at a full FIFO is dropped and sets a sticky overflow flag, which only an explicit clear removes. After a run completes, the block ignores triggers until the control word is written again.

Top module: `acq_sequencer`

## Requirements
- R1: A trigger (`sw_trig` or `ext_trig` high at a clock edge) is ignored when control bit 0 (acquisition enable) is 0, when a run is already in progress, or after a run has completed; any write to the control word re-arms the block.
- R2: An accepted trigger sets `busy` at the next edge. `conv_strobe` is high for one cycle on every underflow of the interval timer. With interval value V the first strobe comes V+1 cycles after the trigger edge, and later strobes come every V+1 cycles.
- R3: With control bit 4 = 0, a run ends (`busy` low after the edge that ends the strobe cycle) after N conversions, where N is the low 16 bits of the count value and 0 means 65536.
- R4: With control bit 4 = 1, the count is the full 32-bit value (0 means 2^32), so runs of 65,537 or more conversions complete exactly.
- R5: With control bit 2 (scan enable) = 1 and bit 3 = 0, the scan pointer advances once per conversion. `conv_chan`/`conv_gain` show the entry at the pointer. An entry is written as `sl_wdata[3:0]` channel, `[5:4]` gain and `[6]` last flag. The pointer wraps to 0 after an entry whose last flag is set, or after the final slot.
- R6: With control bit 2 = 0, every conversion of the run uses scan entry 0.
- R7: With control bits 2 and 3 both 1, the pointer advances once every D+1 conversions, where D is the divide value.
- R8: The scan pointer and the divide count return to 0 at the start of each run.
- R9: With control bit 5 = 1, a 12-bit code c is stored as 0x0000 + c (range 0x0000..0x0FFF).
- R10: With control bit 5 = 0, code c is stored as the 16-bit two's complement of c - 2048 (0x000 gives 0xF800, 0xFFF gives 0x07FF).
- R11: `dma_req` is high exactly when control bit 1 (DMA enable) is 1 and the result FIFO is not empty.
- R12: A result arriving while the FIFO is full is dropped and sets `overflow`. `overflow` stays set until `ovf_clr` is asserted in a cycle with no such drop.
- R13: After reset the block is idle: `busy`, `conv_strobe`, `dma_req` and `overflow` are 0, `fifo_empty` is 1, and the control word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control word (also re-arms) |
| ctl_wdata | input | 6 | Control word: 0 acq enable, 1 DMA enable, 2 scan enable, 3 scan divide, 4 wide count, 5 unsigned format |
| ivl_we | input | 1 | Write strobe for the interval reload value |
| ivl_wdata | input | 16 | Interval reload value V (period V+1 cycles) |
| cnt_we | input | 1 | Write strobe for the conversion count |
| cnt_wdata | input | 32 | Number of conversions per run |
| div_we | input | 1 | Write strobe for the scan-divide value |
| div_wdata | input | 8 | Scan-divide value D |
| sl_we | input | 1 | Scan-list write strobe |
| sl_addr | input | 4 | Scan-list entry index |
| sl_wdata | input | 7 | Scan entry: channel [3:0], gain [5:4], last [6] |
| sw_trig | input | 1 | Software start trigger |
| ext_trig | input | 1 | External start trigger |
| conv_strobe | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_gain | output | 2 | Gain code for the current conversion |
| busy | output | 1 | Run in progress |
| adc_valid | input | 1 | Converter result valid |
| adc_code | input | 12 | Raw converter code |
| fifo_rd | input | 1 | Pop the head of the result FIFO |
| fifo_dout | output | 16 | Formatted result at the FIFO head |
| fifo_empty | output | 1 | Result FIFO empty |
| dma_req | output | 1 | DMA request |
| ovf_clr | input | 1 | Clear the overflow flag |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
A behavioural model is compared with the design on every clock. The sequencing is run with a short per-conversion scan that wraps at a flagged entry, with scanning disabled at the fastest interval, and with a divided scan advance; together these separate a per-conversion pointer step from a divided one, and a flag-driven wrap from reuse of a fixed entry. Two back-to-back runs show whether the pointer restarts at zero. Codes at the ends and middle of the 12-bit range are pushed in both formats, which separates the MSB inversion and sign extension from plain zero-extension. A FIFO fill past capacity exercises the dropped push and the sticky overflow. A 16-bit run with count 0 (65536 conversions) and a 32-bit run of 65537 conversions test the terminal count and the borrow between the cascaded stages.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int ADC_W  = 12;
  localparam int OUT_W  = 16;
  localparam int CHAN_W = 4;
  localparam int GAIN_W = 2;
  localparam int CTL_W  = 6;
  localparam int ENT_W  = CHAN_W + GAIN_W + 1;

  typedef struct packed {
    logic fmt_unsigned;  // bit 5
    logic wide_cnt;      // bit 4
    logic scan_div;      // bit 3
    logic scan_en;       // bit 2
    logic dma_en;        // bit 1
    logic acq_en;        // bit 0
  } acq_ctl_t;

  typedef struct packed {
    logic              last;
    logic [GAIN_W-1:0] gain;
    logic [CHAN_W-1:0] chan;
  } scan_ent_t;

  // Offset-binary code -> stored word
  function automatic logic [OUT_W-1:0] fmt_result(input logic [ADC_W-1:0] code,
                                                  input logic straight);
    logic [ADC_W-1:0] flipped;
    flipped = {~code[ADC_W-1], code[ADC_W-2:0]};
    if (straight) return {{(OUT_W-ADC_W){1'b0}}, code};
    return {{(OUT_W-ADC_W){flipped[ADC_W-1]}}, flipped};
  endfunction
endpackage

// File: rtl/acq_interval_timer.sv
module acq_interval_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= reload;
    else if (run) begin
      if (cnt_q == '0)   cnt_q <= reload;
      else               cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/acq_conv_counter.sv
module acq_conv_counter #(
  parameter int SEG_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [2*SEG_W-1:0] load_val,
  input  logic               dec,
  input  logic               wide,
  output logic               at_terminal
);
  logic [SEG_W-1:0] lo_q, hi_q;
  logic             lo_zero;

  assign lo_zero     = (lo_q == '0);
  assign at_terminal = lo_zero && (!wide || (hi_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= load_val[SEG_W-1:0];
      hi_q <= load_val[2*SEG_W-1:SEG_W];
    end else if (dec) begin
      lo_q <= lo_q - 1'b1;
      if (wide && lo_zero) hi_q <= hi_q - 1'b1;
    end
  end
endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
  import acq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  scan_ent_t        wr_data,
  input  logic             restart,
  input  logic             conv,
  input  logic             scan_en,
  input  logic             scan_div,
  input  logic [DIV_W-1:0] div_val,
  output scan_ent_t        cur_ent,
  output logic [AW-1:0]    ptr,
  output logic             advance
);
  scan_ent_t        mem_q [DEPTH];
  logic [AW-1:0]    ptr_q;
  logic [DIV_W-1:0] divc_q;
  logic             div_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                          mem_q[g] <= '0;
      else if (wr_en && wr_addr == AW'(g)) mem_q[g] <= wr_data;
    end
  end

  assign div_hit = (divc_q == div_val);
  assign advance = conv && scan_en && (!scan_div || div_hit);
  assign cur_ent = scan_en ? mem_q[ptr_q] : mem_q[0];
  assign ptr     = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ptr_q  <= '0;
      divc_q <= '0;
    end else begin
      if (conv && scan_en && scan_div)
        divc_q <= div_hit ? '0 : divc_q + 1'b1;
      if (advance)
        ptr_q <= (mem_q[ptr_q].last || ptr_q == AW'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/acq_result_fifo.sv
module acq_result_fifo #(
  parameter int DEPTH = 8,
  parameter int W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         ovf_clr,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         overflow
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      if (push && full) overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int IVL_W      = 16,
  parameter int SEG_W      = 16,
  parameter int SL_DEPTH   = 16,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 8,
  localparam int SL_AW = $clog2(SL_DEPTH),
  localparam int CNT_W = 2 * SEG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic                 ivl_we,
  input  logic [IVL_W-1:0]     ivl_wdata,
  input  logic                 cnt_we,
  input  logic [CNT_W-1:0]     cnt_wdata,
  input  logic                 div_we,
  input  logic [DIV_W-1:0]     div_wdata,
  input  logic                 sl_we,
  input  logic [SL_AW-1:0]     sl_addr,
  input  logic [ENT_W-1:0]     sl_wdata,
  input  logic                 sw_trig,
  input  logic                 ext_trig,
  output logic                 conv_strobe,
  output logic [CHAN_W-1:0]    conv_chan,
  output logic [GAIN_W-1:0]    conv_gain,
  output logic                 busy,
  input  logic                 adc_valid,
  input  logic [ADC_W-1:0]     adc_code,
  input  logic                 fifo_rd,
  output logic [OUT_W-1:0]     fifo_dout,
  output logic                 fifo_empty,
  output logic                 dma_req,
  input  logic                 ovf_clr,
  output logic                 overflow
);
  acq_ctl_t         ctl_q;
  logic [IVL_W-1:0] ivl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             busy_q, done_q;

  // Named internal events
  logic             run_start, conv_evt, run_last, run_end, ptr_adv, push_evt;
  logic [OUT_W-1:0] push_data;
  logic [SL_AW-1:0] scan_ptr;
  scan_ent_t        cur_ent;
  logic             cfg_acq_en, cfg_dma_en, cfg_fmt_unsigned;

  assign cfg_acq_en       = ctl_q.acq_en;
  assign cfg_dma_en       = ctl_q.dma_en;
  assign cfg_fmt_unsigned = ctl_q.fmt_unsigned;

  assign run_start = cfg_acq_en && !busy_q && !done_q && (sw_trig || ext_trig);
  assign run_end   = conv_evt && run_last;
  assign push_evt  = adc_valid;
  assign push_data = fmt_result(adc_code, cfg_fmt_unsigned);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      ivl_q  <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= acq_ctl_t'(ctl_wdata);
      if (ivl_we) ivl_q <= ivl_wdata;
      if (cnt_we) cnt_q <= cnt_wdata;
      if (div_we) div_q <= div_wdata;
      if (run_start)    busy_q <= 1'b1;
      else if (run_end) busy_q <= 1'b0;
      if (run_end)      done_q <= 1'b1;
      else if (ctl_we)  done_q <= 1'b0;
    end
  end

  acq_interval_timer #(.W(IVL_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (run_start),
    .run    (busy_q),
    .reload (ivl_q),
    .tick   (conv_evt)
  );

  acq_conv_counter #(.SEG_W(SEG_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (run_start),
    .load_val    (cnt_q - 1'b1),
    .dec         (conv_evt),
    .wide        (ctl_q.wide_cnt),
    .at_terminal (run_last)
  );

  acq_scan_seq #(.DEPTH(SL_DEPTH), .DIV_W(DIV_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sl_we),
    .wr_addr  (sl_addr),
    .wr_data  (scan_ent_t'(sl_wdata)),
    .restart  (run_start),
    .conv     (conv_evt),
    .scan_en  (ctl_q.scan_en),
    .scan_div (ctl_q.scan_div),
    .div_val  (div_q),
    .cur_ent  (cur_ent),
    .ptr      (scan_ptr),
    .advance  (ptr_adv)
  );

  acq_result_fifo #(.DEPTH(FIFO_DEPTH), .W(OUT_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_evt),
    .push_data (push_data),
    .pop       (fifo_rd),
    .ovf_clr   (ovf_clr),
    .dout      (fifo_dout),
    .empty     (fifo_empty),
    .overflow  (overflow)
  );

  assign conv_strobe = conv_evt;
  assign conv_chan   = cur_ent.chan;
  assign conv_gain   = cur_ent.gain;
  assign busy        = busy_q;
  assign dma_req     = cfg_dma_en && !fifo_empty;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int PTR_W = 4,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_en,
  input logic             dma_en,
  input logic             fmt_unsigned,
  input logic             sw_trig,
  input logic             ext_trig,
  input logic             busy,
  input logic             conv_strobe,
  input logic             run_start,
  input logic             run_last,
  input logic [PTR_W-1:0] ptr,
  input logic             push_evt,
  input logic [OUT_W-1:0] push_data,
  input logic             dma_req,
  input logic             fifo_empty,
  input logic             overflow,
  input logic             ovf_clr
);
  // R1
  ign_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig || ext_trig) && !acq_en && !busy |=> !busy);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> busy);
  // R2
  strobe_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> busy);
  // R3
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe && run_last |=> !busy);
  // R8
  ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (ptr == '0));
  // R9
  unsigned_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt && fmt_unsigned |-> (push_data[OUT_W-1:12] == '0));
  // R10
  signed_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt && !fmt_unsigned |->
      ($countones(push_data[OUT_W-1:11]) == 0 || $countones(push_data[OUT_W-1:11]) == OUT_W-11));
  // R11
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);
  // R11
  dma_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !fifo_empty);
  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow);
endmodule

bind acq_sequencer acq_sequencer_chk #(.PTR_W(SL_AW), .OUT_W(acq_pkg::OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acq_en       (cfg_acq_en),
  .dma_en       (cfg_dma_en),
  .fmt_unsigned (cfg_fmt_unsigned),
  .sw_trig      (sw_trig),
  .ext_trig     (ext_trig),
  .busy         (busy),
  .conv_strobe  (conv_strobe),
  .run_start    (run_start),
  .run_last     (run_last),
  .ptr          (scan_ptr),
  .push_evt     (push_evt),
  .push_data    (push_data),
  .dma_req      (dma_req),
  .fifo_empty   (fifo_empty),
  .overflow     (overflow),
  .ovf_clr      (ovf_clr)
);

// File: tb/test_acq_sequencer.sv
module test_acq_sequencer;
  localparam int FD  = 8;
  localparam int SLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ivl_we = 0, cnt_we = 0, div_we = 0, sl_we = 0;
  logic [5:0]  ctl_wdata = 0;
  logic [15:0] ivl_wdata = 0;
  logic [31:0] cnt_wdata = 0;
  logic [7:0]  div_wdata = 0;
  logic [3:0]  sl_addr = 0;
  logic [6:0]  sl_wdata = 0;
  logic sw_trig = 0, ext_trig = 0, adc_valid = 0, fifo_rd = 0, ovf_clr = 0;
  logic [11:0] adc_code = 0;
  logic        conv_strobe, busy, fifo_empty, dma_req, overflow;
  logic [3:0]  conv_chan;
  logic [1:0]  conv_gain;
  logic [15:0] fifo_dout;

  always #2 clk = ~clk;  // 250 MHz

  acq_sequencer i_acq_sequencer (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R13";

  // ---------------- reference model ----------------
  bit [5:0] m_ctl;
  int       m_ivl, m_div, m_timer, m_ptr, m_divc;
  longint   m_cnt, m_left;
  bit       m_busy, m_done, m_ovf;
  int       m_chan[SLD], m_gain[SLD];
  bit       m_lastf[SLD];
  int       q[$];

  function automatic int stored(int code, bit straight);
    int v;
    if (straight) return code;
    v = code - 2048;
    return v & 16'hFFFF;
  endfunction

  bit st, trig_ok, ended;
  int sz;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_ivl = 0; m_div = 0; m_cnt = 0; m_timer = 0; m_ptr = 0; m_divc = 0;
      m_left = 0; m_busy = 0; m_done = 0; m_ovf = 0; q.delete();
      for (int i = 0; i < SLD; i++) begin m_chan[i] = 0; m_gain[i] = 0; m_lastf[i] = 0; end
    end else begin
      st      = m_busy && m_timer == 0;
      trig_ok = m_ctl[0] && !m_busy && !m_done && (sw_trig || ext_trig);
      ended   = 0;
      sz      = q.size();
      if (fifo_rd && sz > 0) void'(q.pop_front());
      if (adc_valid) begin
        if (sz == FD) m_ovf = 1;
        else q.push_back(stored(int'(adc_code), m_ctl[5]));
      end else if (ovf_clr) m_ovf = 0;
      if (trig_ok) begin
        m_busy = 1; m_timer = m_ivl; m_ptr = 0; m_divc = 0;
        if (m_ctl[4]) m_left = (m_cnt == 0) ? 64'd4294967296 : m_cnt;
        else          m_left = ((m_cnt % 65536) == 0) ? 65536 : (m_cnt % 65536);
      end else if (m_busy) begin
        if (st) begin
          m_timer = m_ivl;
          if (m_ctl[2]) begin
            bit adv;
            adv = !m_ctl[3] || (m_divc == m_div);
            if (m_ctl[3]) m_divc = (m_divc == m_div) ? 0 : m_divc + 1;
            if (adv) m_ptr = (m_lastf[m_ptr] || m_ptr == SLD-1) ? 0 : m_ptr + 1;
          end
          m_left--;
          if (m_left == 0) begin m_busy = 0; m_done = 1; ended = 1; end
        end else m_timer--;
      end
      if (ctl_we) begin m_ctl = ctl_wdata; if (!ended) m_done = 0; end
      if (ivl_we) m_ivl = ivl_wdata;
      if (cnt_we) m_cnt = cnt_wdata;
      if (div_we) m_div = div_wdata;
      if (sl_we) begin
        m_chan[sl_addr] = sl_wdata[3:0]; m_gain[sl_addr] = sl_wdata[5:4]; m_lastf[sl_addr] = sl_wdata[6];
      end
    end
  end

  task automatic chk(string tag, longint got, longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s [%s] got %0h expected %0h at cycle %0d", tag, phase, got, exp, cyc);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int e;
      e = m_ctl[2] ? m_ptr : 0;
      chk("R2 strobe", conv_strobe, m_busy && m_timer == 0);
      chk("R3 busy", busy, m_busy);
      chk("R5 chan", conv_chan, m_chan[e]);
      chk("R5 gain", conv_gain, m_gain[e]);
      chk("R12 empty", fifo_empty, q.size() == 0);
      if (q.size() > 0) chk("R9/R10 dout", fifo_dout, q[0]);
      chk("R11 dma", dma_req, m_ctl[1] && q.size() > 0);
      chk("R12 ovf", overflow, m_ovf);
    end
    if (cyc > 199000) begin
      n_bad++;
      $display("FAIL watchdog [%s] got timeout expected completion", phase);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr_ctl(logic [5:0] v);  ctl_wdata = v; ctl_we = 1; tick(); ctl_we = 0; endtask
  task automatic wr_ivl(int v); ivl_wdata = 16'(v); ivl_we = 1; tick(); ivl_we = 0; endtask
  task automatic wr_cnt(longint v); cnt_wdata = 32'(v); cnt_we = 1; tick(); cnt_we = 0; endtask
  task automatic wr_div(int v); div_wdata = 8'(v); div_we = 1; tick(); div_we = 0; endtask
  task automatic wr_sl(int a, int ch, int g, bit l);
    sl_addr = 4'(a); sl_wdata = {l, 2'(g), 4'(ch)}; sl_we = 1; tick(); sl_we = 0;
  endtask
  task automatic trig(bit ext);
    if (ext) ext_trig = 1; else sw_trig = 1;
    tick(); ext_trig = 0; sw_trig = 0;
  endtask
  task automatic wait_idle();
    int guard = 0;
    tick();
    while (m_busy && guard < 150000) begin tick(); guard++; end
    tick(2);
  endtask
  task automatic push(int code); adc_code = 12'(code); adc_valid = 1; tick(); adc_valid = 0; endtask
  task automatic pop(); fifo_rd = 1; tick(); fifo_rd = 0; endtask

  initial begin
    tick(4);
    rst_n = 1;
    tick();
    #1;
    phase = "R13";
    chk("R13 busy", busy, 0);
    chk("R13 strobe", conv_strobe, 0);
    chk("R13 empty", fifo_empty, 1);
    chk("R13 ovf", overflow, 0);
    chk("R13 dma", dma_req, 0);
    tick();

    wr_sl(0, 5, 0, 0); wr_sl(1, 2, 1, 0); wr_sl(2, 9, 2, 0); wr_sl(3, 7, 3, 1);
    wr_sl(15, 12, 1, 0);

    phase = "R1 disabled";
    wr_ivl(3); wr_cnt(10);
    trig(0); tick(3); trig(1); tick(5);
    chk("R1 no run", busy, 0);

    phase = "R2 R3 R5 scan run";
    wr_ctl(6'b000101);
    trig(0);
    chk("R2 busy after trigger", busy, 1);
    wait_idle();
    phase = "R1 done ignore";
    trig(1); tick(3);
    chk("R1 done ignores trigger", busy, 0);

    phase = "R6 single channel";
    wr_ctl(6'b000001); wr_ivl(0); wr_cnt(5);
    trig(1);
    chk("R6 run started", busy, 1);
    wait_idle();

    phase = "R7 scan divide";
    wr_ctl(6'b001101); wr_ivl(1); wr_div(2); wr_cnt(14);
    trig(0); wait_idle();

    phase = "R8 restart";
    wr_ctl(6'b000101); wr_ivl(2); wr_cnt(2);
    trig(0); wait_idle();
    wr_ctl(6'b000101);
    trig(0);
    chk("R8 second run", busy, 1);
    wait_idle();

    phase = "R9 unsigned";
    wr_ctl(6'b100010);
    push(12'h000); push(12'hFFF); push(12'h800); push(12'h123);
    chk("R11 dma high", dma_req, 1);
    repeat (4) pop();
    phase = "R10 signed";
    wr_ctl(6'b000010);
    push(12'h000); push(12'hFFF); push(12'h800); push(12'h7FF); push(12'h123);
    chk("R10 first word", fifo_dout, 16'hF800);
    repeat (5) pop();
    phase = "R11 dma off";
    wr_ctl(6'b000000);
    push(12'h456);
    chk("R11 dma disabled", dma_req, 0);
    pop();

    phase = "R12 overflow";
    wr_ctl(6'b000010);
    for (int i = 0; i < FD + 2; i++) push(i * 100);
    chk("R12 ovf set", overflow, 1);
    pop(); pop(); tick(2);
    chk("R12 ovf sticky", overflow, 1);
    ovf_clr = 1; tick(); ovf_clr = 0;
    chk("R12 ovf cleared", overflow, 0);
    while (q.size() > 0) pop();

    phase = "R3 narrow count zero";
    wr_ctl(6'b000001); wr_ivl(0); wr_cnt(0);
    trig(0); wait_idle();
    chk("R3 ended", busy, 0);

    phase = "R4 wide 65537";
    wr_ctl(6'b010001); wr_cnt(65537);
    trig(1); wait_idle();
    chk("R4 ended", busy, 0);

    tick(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule